// File: doc/BRIEF.md
# Row-Column Matrix Single-Bit RAM

This block is a 256-location, one-bit-wide storage array. A cell is picked by two 16-way one-hot decoders. The upper address nibble selects a row and the lower nibble selects a column. Only the cell where the active row and the active column cross reacts to the shared control lines. An active-low chip select gates every operation. Writes are steered by two separate bit lines, a set line that stores a 1 and a clear line that stores a 0. A select with neither line asserted is a read. Since tri-state pins are not used inside a chip, the output is modelled as a data bit plus a drive enable. When the enable is low, the data bit is forced to 0 and the output counts as high-impedance.

The block also contains a timing monitor. The address and bit lines may only move while chip select is high. They must be quiet for a setup window before chip select falls, and for a hold window after it rises. Both windows are parameters counted in clock edges. Any breach raises a sticky timing flag. A select that asserts both bit lines together is refused and raises a separate sticky flag.

Everything is sampled on the rising clock edge. Read data and the drive enable appear one edge after the edge at which the read is sampled.

Top module: `matrix_bit_ram`

## Requirements
- R1: `addr[7:4]` selects the row and `addr[3:0]` selects the column. Each of the 256 addresses maps to its own cell, and a write to one address leaves every other address unchanged.
- R2: On an edge where `cs_n`=0, `wr_set`=1 and `wr_clr`=0, the addressed cell becomes 1.
- R3: On an edge where `cs_n`=0, `wr_set`=0 and `wr_clr`=1, the addressed cell becomes 0.
- R4: On an edge where `cs_n`=0 and both bit lines are 0, the next cycle shows `dout_en`=1 and `dout` equal to the addressed cell, and the cell content is unchanged.
- R5: After any edge that is not a read (`cs_n`=1, or any bit line at 1), `dout_en`=0 and `dout`=0 (high-impedance) in the next cycle.
- R6: While `cs_n`=1, the bit lines have no effect on any cell.
- R7: On an edge where `cs_n`=0 and both bit lines are 1, the cell is not written, and `line_clash` is 1 from the next cycle until reset.
- R8: Setup rule. Let e be the first edge at which `cs_n` is sampled 0. If the address or either bit line sampled at e differs from the value sampled at any of the SETUP_CYC edges before e, `timing_fault` rises in the next cycle.
- R9: If the address or a bit line differs from its value at the previous edge while `cs_n` is sampled 0 on both edges, `timing_fault` rises in the next cycle.
- R10: Hold rule. Let j be the first edge at which `cs_n` is sampled 1 again after an active period. An input change sampled at any of edges j through j+HOLD_CYC-1 raises `timing_fault`. A change first seen at edge j+HOLD_CYC is legal.
- R11: `timing_fault` stays at 1 until reset, and accesses that meet all timing rules never set it.
- R12: After reset, every cell holds 0, and `dout`, `dout_en`, `line_clash` and `timing_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 8 | Cell address: row nibble above, column nibble below |
| wr_set | input | 1 | Bit line that writes a 1 |
| wr_clr | input | 1 | Bit line that writes a 0 |
| dout | output | 1 | Read data, 0 when not driven |
| dout_en | output | 1 | Output drive enable; 0 means high-impedance |
| line_clash | output | 1 | Sticky: both bit lines were asserted during a select |
| timing_fault | output | 1 | Sticky: setup, active-stability or hold rule broken |

## Verification
The bench walks every address with distinct values, so a swapped or mis-split row/column decode shows up as aliasing on readback. It also runs random compliant accesses against a memory model. Both timing windows are probed one edge short of the limit and exactly at it. A monitor that is off by one edge either flags legal traffic or misses the violation. Other directed checks confirm that a clashing select leaves the cell alone, and that bit lines toggled with chip select high write nothing. A design that merged the two write lines or ignored chip select would corrupt the modelled contents.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_SET,
        OP_CLR,
        OP_CLASH
    } op_e;

    typedef enum logic [1:0] {
        MON_OPEN,
        MON_ACTIVE,
        MON_HOLD
    } mon_e;

endpackage

// File: rtl/mbr_decoder.sv
module mbr_decoder #(
    parameter int IN_W = 4,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  sel,
    output logic [OUT_N-1:0] hot
);

    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign hot[i] = (sel == IN_W'(i));
    end

endmodule

// File: rtl/mbr_array.sv
module mbr_array #(
    parameter int ROWS = 16,
    parameter int COLS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] row_hot,
    input  logic [COLS-1:0] col_hot,
    input  logic            we,
    input  logic            wbit,
    output logic            rbit
);

    logic [ROWS*COLS-1:0] hit_bits;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic cell_q;
            logic pick;

            assign pick = row_hot[r] & col_hot[c];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q <= 1'b0;
                end else if (we && pick) begin
                    cell_q <= wbit;
                end
            end

            assign hit_bits[r*COLS+c] = pick & cell_q;
        end
    end

    assign rbit = |hit_bits;

endmodule

// File: rtl/mbr_opctl.sv
module mbr_opctl
    import mbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_set,
    input  logic wr_clr,
    input  logic rbit,
    output logic we,
    output logic wbit,
    output logic dout,
    output logic dout_en,
    output logic line_clash
);

    op_e  op_d;
    op_e  op_q;
    logic rd_q;
    logic clash_q;

    always_comb begin
        unique case ({cs_n, wr_set, wr_clr})
            3'b000:  op_d = OP_READ;
            3'b010:  op_d = OP_SET;
            3'b001:  op_d = OP_CLR;
            3'b011:  op_d = OP_CLASH;
            default: op_d = OP_NONE;
        endcase
    end

    assign we   = (op_d == OP_SET) || (op_d == OP_CLR);
    assign wbit = (op_d == OP_SET);

    // State register: last operation, captured read bit, sticky clash flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            rd_q    <= 1'b0;
            clash_q <= 1'b0;
        end else begin
            op_q <= op_d;
            if (op_d == OP_READ) begin
                rd_q <= rbit;
            end
            if (op_d == OP_CLASH) begin
                clash_q <= 1'b1;
            end
        end
    end

    // Output decode from the registered operation
    always_comb begin
        dout_en = 1'b0;
        dout    = 1'b0;
        unique case (op_q)
            OP_READ: begin
                dout_en = 1'b1;
                dout    = rd_q;
            end
            OP_NONE, OP_SET, OP_CLR, OP_CLASH: begin
                dout_en = 1'b0;
                dout    = 1'b0;
            end
            default: begin
                dout_en = 1'b0;
                dout    = 1'b0;
            end
        endcase
        line_clash = clash_q;
    end

endmodule

// File: rtl/mbr_timing_mon.sv
module mbr_timing_mon
    import mbr_pkg::*;
#(
    parameter int IN_W      = 10,
    parameter int SETUP_CYC = 25,
    parameter int HOLD_CYC  = 125,
    localparam int STAB_W   = $clog2(SETUP_CYC + 2),
    localparam int REM_W    = (HOLD_CYC > 1) ? $clog2(HOLD_CYC + 1) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic [IN_W-1:0] watched,
    output logic            fault
);

    localparam logic [STAB_W-1:0] STAB_MAX = STAB_W'(SETUP_CYC);
    localparam logic [REM_W-1:0]  REM_INIT = (HOLD_CYC > 1) ? REM_W'(HOLD_CYC - 1) : '0;

    mon_e              st_q, st_d;
    logic [IN_W-1:0]   last_q;
    logic              seen_q;
    logic [STAB_W-1:0] stab_q, stab_now;
    logic [REM_W-1:0]  rem_q, rem_d;
    logic              fault_q;
    logic              chg;
    logic              setup_bad;
    logic              viol;

    assign chg       = seen_q && (watched != last_q);
    assign stab_now  = chg ? '0 : ((stab_q >= STAB_MAX) ? STAB_MAX : stab_q + 1'b1);
    assign setup_bad = (stab_now < STAB_MAX);

    // Next-state and violation decode
    always_comb begin
        st_d  = st_q;
        rem_d = rem_q;
        viol  = 1'b0;
        unique case (st_q)
            MON_OPEN: begin
                if (!cs_n) begin
                    viol = setup_bad;
                    st_d = MON_ACTIVE;
                end
            end
            MON_ACTIVE: begin
                if (!cs_n) begin
                    viol = chg;
                end else begin
                    viol = chg && (HOLD_CYC > 0);
                    if (HOLD_CYC > 1) begin
                        st_d  = MON_HOLD;
                        rem_d = REM_INIT;
                    end else begin
                        st_d = MON_OPEN;
                    end
                end
            end
            MON_HOLD: begin
                if (!cs_n) begin
                    viol = setup_bad;
                    st_d = MON_ACTIVE;
                end else begin
                    viol = chg;
                    if (rem_q <= REM_W'(1)) begin
                        st_d = MON_OPEN;
                    end else begin
                        rem_d = rem_q - 1'b1;
                    end
                end
            end
            default: st_d = MON_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= MON_OPEN;
            rem_q   <= '0;
            last_q  <= '0;
            seen_q  <= 1'b0;
            stab_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            rem_q   <= rem_d;
            last_q  <= watched;
            seen_q  <= 1'b1;
            stab_q  <= stab_now;
            fault_q <= fault_q | viol;
        end
    end

    assign fault = fault_q;

endmodule

// File: rtl/matrix_bit_ram.sv
module matrix_bit_ram #(
    parameter int ADDR_W    = 8,
    parameter int SETUP_CYC = 25,
    parameter int HOLD_CYC  = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_set,
    input  logic              wr_clr,
    output logic              dout,
    output logic              dout_en,
    output logic              line_clash,
    output logic              timing_fault
);

    localparam int ROW_W = ADDR_W / 2;
    localparam int COL_W = ADDR_W - ROW_W;
    localparam int ROWS  = 1 << ROW_W;
    localparam int COLS  = 1 << COL_W;
    localparam int MON_W = ADDR_W + 2;

    logic [ROWS-1:0] row_hot;
    logic [COLS-1:0] col_hot;
    logic            we;
    logic            wbit;
    logic            rbit;

    mbr_decoder #(.IN_W(ROW_W)) u_row_dec (
        .sel (addr[ADDR_W-1:COL_W]),
        .hot (row_hot)
    );

    mbr_decoder #(.IN_W(COL_W)) u_col_dec (
        .sel (addr[COL_W-1:0]),
        .hot (col_hot)
    );

    mbr_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_hot (row_hot),
        .col_hot (col_hot),
        .we      (we),
        .wbit    (wbit),
        .rbit    (rbit)
    );

    mbr_opctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .wr_set     (wr_set),
        .wr_clr     (wr_clr),
        .rbit       (rbit),
        .we         (we),
        .wbit       (wbit),
        .dout       (dout),
        .dout_en    (dout_en),
        .line_clash (line_clash)
    );

    mbr_timing_mon #(
        .IN_W      (MON_W),
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .watched ({addr, wr_set, wr_clr}),
        .fault   (timing_fault)
    );

endmodule

// File: rtl/mbr_checker.sv
module mbr_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_set,
    input logic              wr_clr,
    input logic              dout,
    input logic              dout_en,
    input logic              line_clash,
    input logic              timing_fault
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R4: drive enable only follows a read select
    a_r4_drive_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && dout_en |-> $past(!cs_n && !wr_set && !wr_clr));

    // R5: no drive after a non-read edge
    a_r5_hiz_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || wr_set || wr_clr) |=> (!dout_en && !dout));

    // R7: clashing bit lines raise the flag
    a_r7_clash_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && wr_set && wr_clr) |=> line_clash);

    // R7: clash flag is sticky
    a_r7_clash_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        line_clash |=> line_clash);

    // R9: input change inside active window
    a_r9_active_change: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !cs_n && $past(!cs_n) && ({addr, wr_set, wr_clr} != $past({addr, wr_set, wr_clr})))
        |=> timing_fault);

    // R11: timing flag is sticky
    a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        timing_fault |=> timing_fault);

endmodule

bind matrix_bit_ram mbr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .addr         (addr),
    .wr_set       (wr_set),
    .wr_clr       (wr_clr),
    .dout         (dout),
    .dout_en      (dout_en),
    .line_clash   (line_clash),
    .timing_fault (timing_fault)
);

// File: tb/sim_matrix_bit_ram.sv
`timescale 1ns/1ps
module sim_matrix_bit_ram;

    localparam int SU = 3;
    localparam int HD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [7:0] addr = '0;
    logic       wr_set = 1'b0;
    logic       wr_clr = 1'b0;
    logic       dout, dout_en, line_clash, timing_fault;

    int checks = 0;
    int fails  = 0;
    bit model_mem [256];
    bit done = 1'b0;

    always #2 clk = ~clk;

    matrix_bit_ram #(.ADDR_W(8), .SETUP_CYC(SU), .HOLD_CYC(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr),
        .wr_set(wr_set), .wr_clr(wr_clr), .dout(dout), .dout_en(dout_en),
        .line_clash(line_clash), .timing_fault(timing_fault)
    );

    function automatic bit exp_after(bit old, bit s, bit c);
        if (s && !c) return 1'b1;
        if (c && !s) return 1'b0;
        return old;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1; addr = '0; wr_set = 1'b0; wr_clr = 1'b0;
        tick(2);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) model_mem[i] = 1'b0;
        tick(SU + 1);
    endtask

    // Compliant access: inputs settle, one active edge, hold respected
    task automatic access(input logic [7:0] a, input bit s, input bit c, input string req);
        addr = a; wr_set = s; wr_clr = c;
        tick(SU);
        cs_n = 1'b0;
        tick(1);
        if (!s && !c) begin
            chk(dout_en === 1'b1, {req, " read enable"}, int'(dout_en), 1);
            chk(dout === model_mem[a], {req, " read data"}, int'(dout), int'(model_mem[a]));
        end else begin
            chk(dout_en === 1'b0 && dout === 1'b0, "R5 hiz on write", int'(dout_en), 0);
        end
        model_mem[a] = exp_after(model_mem[a], s, c);
        cs_n = 1'b1;
        tick(1);
        chk(dout_en === 1'b0, "R5 hiz when deselected", int'(dout_en), 0);
        tick(HD - 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R12 reset state
        chk(dout_en === 0 && dout === 0, "R12 outputs after reset", int'(dout_en), 0);
        chk(line_clash === 0 && timing_fault === 0, "R12 flags after reset", int'(line_clash), 0);
        access(8'h5A, 0, 0, "R12 cell cleared");

        // R1 walk: write pattern over all addresses then read back
        for (int i = 0; i < 256; i++) access(8'(i), (i % 3) == 0, (i % 3) != 0, "R1 write");
        for (int i = 0; i < 256; i++) access(8'(i), 0, 0, "R1 readback");

        // R2/R3 set and clear on one cell
        access(8'h37, 1, 0, "R2 set");
        access(8'h37, 0, 0, "R2 read set");
        access(8'h37, 0, 1, "R3 clear");
        access(8'h37, 0, 0, "R3 read clear");
        // R4 repeated read leaves content
        access(8'h37, 0, 0, "R4 reread");

        // R6 bit lines toggled with chip select high
        addr = 8'h81; wr_set = 1'b1; tick(2); wr_set = 1'b0; wr_clr = 1'b1; tick(2);
        wr_clr = 1'b0; tick(1);
        chk(dout_en === 0, "R6 no drive deselected", int'(dout_en), 0);
        access(8'h81, 0, 0, "R6 content unchanged");
        access(8'h00, 0, 0, "R6 other cell unchanged");

        // Random compliant traffic
        for (int k = 0; k < 400; k++) begin
            logic [7:0] ra;
            int op;
            ra = 8'($urandom_range(0, 255));
            op = int'($urandom_range(0, 2));
            access(ra, op == 1, op == 2, "R4 random");
        end
        chk(timing_fault === 0, "R11 clean traffic no fault", int'(timing_fault), 0);
        chk(line_clash === 0, "R7 no clash yet", int'(line_clash), 0);

        // R7 clash
        access(8'h44, 1, 0, "R7 prep");
        access(8'h44, 1, 1, "R7 clash");
        chk(line_clash === 1, "R7 clash flag", int'(line_clash), 1);
        access(8'h44, 0, 0, "R7 cell unchanged");
        access(8'h45, 0, 0, "R7 flag sticky read");
        chk(line_clash === 1, "R7 clash sticky", int'(line_clash), 1);
        chk(timing_fault === 0, "R11 clash is not timing", int'(timing_fault), 0);

        // R8 setup exactly at limit: legal
        do_reset();
        addr = 8'h12; tick(SU); cs_n = 1'b0; tick(1); cs_n = 1'b1; tick(1);
        chk(timing_fault === 0, "R8 setup at limit", int'(timing_fault), 0);
        tick(HD);
        // R8 setup one edge short
        addr = 8'h13; tick(SU - 1); cs_n = 1'b0; tick(1);
        chk(timing_fault === 1, "R8 setup short", int'(timing_fault), 1);
        cs_n = 1'b1; tick(HD + SU);
        access(8'h13, 0, 0, "R11 sticky after setup");
        chk(timing_fault === 1, "R11 fault sticky", int'(timing_fault), 1);

        // R9 change during active window
        do_reset();
        addr = 8'h20; tick(SU); cs_n = 1'b0; tick(1);
        chk(timing_fault === 0, "R9 clean start", int'(timing_fault), 0);
        addr = 8'h21; tick(1);
        chk(timing_fault === 1, "R9 active change", int'(timing_fault), 1);
        cs_n = 1'b1; tick(HD + 1);

        // R10 hold exactly at limit: legal
        do_reset();
        addr = 8'h30; tick(SU); cs_n = 1'b0; tick(1); cs_n = 1'b1;
        tick(HD); addr = 8'h31; tick(1);
        chk(timing_fault === 0, "R10 hold at limit", int'(timing_fault), 0);
        // R10 hold one edge short
        tick(SU); cs_n = 1'b0; tick(1); cs_n = 1'b1;
        tick(HD - 1); addr = 8'h32; tick(1);
        chk(timing_fault === 1, "R10 hold short", int'(timing_fault), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule